// File: doc/BRIEF.md
# Slot bus access sequencer

This block is the host side of a multiplexed cartridge slot bus. It turns one request from the host into a timed sequence of 16-bit transfers on a 24-bit address/data bus. It drives an active-low chip select, separate active-low read and write strobes, a free-running bus clock at half the internal clock rate, and per-line output enables for the address/data lines. A request can be a single halfword, a double transfer that moves one 32-bit value as two halfwords (low half first), or a burst of up to 255 halfwords.

The bus timing is counted in bus clock periods, two internal clocks each. A 16-bit configuration word, presented with each request, chooses one of six known timing pairs: a length for the first halfword and a length for each halfword after it. Any other value falls back to a pair of six and six. A transfer can start on any internal clock edge, so it can begin in either phase of the bus clock. The access opens with one bus cycle that drives the address on all 24 lines. Each halfword then takes one strobe-high bus cycle followed by length-minus-one strobe-low cycles. One closing bus cycle follows the last halfword, and then the chip select rises.

The host holds its request until the block accepts it, which happens on the next edge while the block is idle. A one-clock acknowledge marks the end of the access and carries the assembled read data. A one-clock beat pulse follows each strobe rise. For bursts, the host uses the beat to present the next write halfword.

Top module: `slot_seq`

## Requirements
- R1: While reset is high, and after it, cs_n, rd_n and wr_n are high, ad_oe is all zero and ack and beat are low.
- R2: The timing pair (first/following, in bus cycles) is chosen from req_cfg: 0xE868→6/6, 0xE860→10/6, 0xE870→10/4, 0xE864→8/6, 0xE878→6/4, 0xE86C→18/6. Every other value gives 6/6. One bus cycle is two clk periods.
- R3: A halfword of length L holds its strobe high for the first bus cycle (2 clk) and low for the next L-1 bus cycles (2L-2 clk). The strobe is rd_n for reads and wr_n for writes.
- R4: In a single write (req_type 0, req_we 1), the first halfword is one bus cycle shorter than the programmed first length.
- R5: A double access (req_type 1) moves two halfwords, and the second uses the following length. A write sends req_wdata[15:0] first and then req_wdata[31:16]. A read returns {second, first} on rdata.
- R6: A burst (req_type 2) moves req_len halfwords, with 0 treated as 1. The first uses the first length and the rest use the following length. beat pulses for one clk right after every strobe rise. For a write burst, halfword k≥1 takes req_wdata[15:0] as sampled on the clk edge that ends that halfword's strobe-high bus cycle.
- R7: cs_n is low from the accepting edge for 2·ΣL+2 clk. It rises one bus cycle after the last strobe rise. ack is high for exactly the one clk in which cs_n first returns high.
- R8: During the first bus cycle of an access, ad_oe is all ones, ad_o carries req_addr, and both strobes are high.
- R9: For a read, after the address cycle and while cs_n is low, ad_oe is 0xFF0000 and ad_o[23:16] is zero. ad_i is captured on the rising edge of rd_n. A single read, and each burst halfword, returns {16'h0, data}.
- R10: bus_clk toggles on every clk edge. A request is accepted in either bus_clk phase, with the same timing.
- R11: rd_n and wr_n are never low together, and neither is low while cs_n is high.
- R12: req is ignored while an access is in progress: it neither restarts nor extends the access, and it starts no further one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, accepted while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_type | input | 2 | 0 single, 1 double, 2 burst |
| req_len | input | LEN_W | Burst halfword count (0 counts as 1) |
| req_cfg | input | 16 | Timing selection word |
| req_addr | input | HW_W+HI_W | Address driven in the address cycle |
| req_wdata | input | 2*HW_W | Write data; low half refreshed during write bursts |
| ack | output | 1 | One-clock end-of-access pulse |
| beat | output | 1 | One-clock pulse after each strobe rise |
| rdata | output | 2*HW_W | Assembled read data |
| bus_clk | output | 1 | Bus clock, half the clk rate |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_o | output | HW_W+HI_W | Address/data output value |
| ad_oe | output | HW_W+HI_W | Per-line output enable |
| ad_i | input | HW_W | Low address/data lines as seen on the bus |

## Verification
If the tick counter or the halfword length it was compared against is wrong, the strobe-low run on rd_n or wr_n comes out the wrong length at the first strobe rise. The bench measures each run in clocks against the decoded table. A wrong halfword count or a wrong tail flag shows up as a wrong cs_n low time when ack arrives, no later than the end of that access. A wrong data-select state shows up at the strobe rise, either as the wrong halfword on ad_o for writes or as wrong rdata at ack for reads. A busy flag that lets a new request through shows up as an extra chip-select fall with no expected access.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int MAX_LEN  = 18;
  localparam int LEN_BITS = $clog2(MAX_LEN + 1);
  localparam int TICK_W   = $clog2(2 * MAX_LEN);

  typedef enum logic [1:0] {
    XF_SINGLE = 2'd0,
    XF_DOUBLE = 2'd1,
    XF_BURST  = 2'd2,
    XF_RSVD   = 2'd3
  } xfer_e;

  typedef logic [LEN_BITS-1:0] len_t;

  // first-halfword length in bus cycles
  function automatic len_t first_len(input logic [15:0] cfg);
    case (cfg)
      16'hE860: return len_t'(10);
      16'hE864: return len_t'(8);
      16'hE868: return len_t'(6);
      16'hE86C: return len_t'(18);
      16'hE870: return len_t'(10);
      16'hE878: return len_t'(6);
      default:  return len_t'(6);
    endcase
  endfunction

  // following-halfword length in bus cycles
  function automatic len_t seq_len(input logic [15:0] cfg);
    case (cfg)
      16'hE870, 16'hE878: return len_t'(4);
      default:            return len_t'(6);
    endcase
  endfunction

  // length of the halfword in progress
  function automatic len_t hw_len(input len_t f, input len_t s,
                                  input logic lead, input logic wr_single);
    if (!lead) return s;
    return wr_single ? f - len_t'(1) : f;
  endfunction
endpackage

// File: rtl/slot_timing_dec.sv
module slot_timing_dec
  import slot_pkg::*;
(
  input  logic [15:0] cfg,
  output len_t        first_o,
  output len_t        seq_o
);
  assign first_o = first_len(cfg);
  assign seq_o   = seq_len(cfg);
endmodule

// File: rtl/slot_clk_div.sv
module slot_clk_div (
  input  logic clk,
  input  logic rst,
  output logic bclk
);
  always_ff @(posedge clk) begin
    if (rst) bclk <= 1'b0;
    else     bclk <= ~bclk;
  end
endmodule

// File: rtl/slot_rd_pack.sv
module slot_rd_pack #(
  parameter int HW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              pair_hi,
  input  logic [HW_W-1:0]   din,
  output logic [2*HW_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (cap)
      rdata <= pair_hi ? {din, rdata[HW_W-1:0]} : {{HW_W{1'b0}}, din};
  end
endmodule

// File: rtl/slot_seq.sv
module slot_seq
  import slot_pkg::*;
#(
  parameter int HW_W  = 16,
  parameter int HI_W  = 8,
  parameter int LEN_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic                 req_we,
  input  logic [1:0]           req_type,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [15:0]          req_cfg,
  input  logic [HW_W+HI_W-1:0] req_addr,
  input  logic [2*HW_W-1:0]    req_wdata,
  output logic                 ack,
  output logic                 beat,
  output logic [2*HW_W-1:0]    rdata,
  output logic                 bus_clk,
  output logic                 cs_n,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic [HW_W+HI_W-1:0] ad_o,
  output logic [HW_W+HI_W-1:0] ad_oe,
  input  logic [HW_W-1:0]      ad_i
);
  localparam int AD_W = HW_W + HI_W;

  logic              busy, tail, lead_hw, we_q, ack_q, beat_q;
  xfer_e             typ_q;
  len_t              first_q, seq_q, dec_first, dec_seq, cur_len;
  logic [LEN_W-1:0]  rem_q, req_count;
  logic [TICK_W-1:0] tick, end_tick;
  logic [HW_W-1:0]   cur_wd, hi_wd;
  logic [AD_W-1:0]   addr_q;

  // named internal events
  logic accept, strobe_on, hw_end, last_hw, tail_end, data_load, addr_phase;

  slot_timing_dec u_dec (.cfg(req_cfg), .first_o(dec_first), .seq_o(dec_seq));
  slot_clk_div    u_div (.clk(clk), .rst(rst), .bclk(bus_clk));

  assign cur_len    = hw_len(first_q, seq_q, lead_hw, we_q && (typ_q == XF_SINGLE));
  assign end_tick   = TICK_W'({cur_len, 1'b0}) - TICK_W'(1);
  assign accept     = req && !busy;
  assign strobe_on  = busy && !tail && (tick >= TICK_W'(2));
  assign hw_end     = busy && !tail && (tick == end_tick);
  assign last_hw    = (rem_q == LEN_W'(1));
  assign tail_end   = tail && (tick == TICK_W'(1));
  assign data_load  = busy && !tail && !lead_hw && (tick == TICK_W'(1));
  assign addr_phase = busy && !tail && lead_hw && (tick < TICK_W'(2));

  always_comb begin
    case (xfer_e'(req_type))
      XF_DOUBLE: req_count = LEN_W'(2);
      XF_BURST:  req_count = (req_len == '0) ? LEN_W'(1) : req_len;
      default:   req_count = LEN_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      tail    <= 1'b0;
      lead_hw <= 1'b0;
      we_q    <= 1'b0;
      typ_q   <= XF_SINGLE;
      first_q <= '0;
      seq_q   <= '0;
      rem_q   <= '0;
      tick    <= '0;
      cur_wd  <= '0;
      hi_wd   <= '0;
      addr_q  <= '0;
      ack_q   <= 1'b0;
      beat_q  <= 1'b0;
    end else begin
      ack_q  <= tail_end;
      beat_q <= hw_end;
      if (accept) begin
        busy    <= 1'b1;
        tail    <= 1'b0;
        lead_hw <= 1'b1;
        tick    <= '0;
        we_q    <= req_we;
        typ_q   <= xfer_e'(req_type);
        first_q <= dec_first;
        seq_q   <= dec_seq;
        rem_q   <= req_count;
        addr_q  <= req_addr;
        cur_wd  <= req_wdata[HW_W-1:0];
        hi_wd   <= req_wdata[2*HW_W-1:HW_W];
      end else if (busy) begin
        if (tail) begin
          if (tail_end) begin
            busy <= 1'b0;
            tail <= 1'b0;
            tick <= '0;
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end else if (hw_end) begin
          tick <= '0;
          if (last_hw) begin
            tail <= 1'b1;
          end else begin
            lead_hw <= 1'b0;
            rem_q   <= rem_q - LEN_W'(1);
          end
        end else begin
          tick <= tick + TICK_W'(1);
          if (data_load)
            cur_wd <= (typ_q == XF_DOUBLE) ? hi_wd : req_wdata[HW_W-1:0];
        end
      end
    end
  end

  slot_rd_pack #(.HW_W(HW_W)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .cap    (hw_end && !we_q),
    .pair_hi(!lead_hw && (typ_q == XF_DOUBLE)),
    .din    (ad_i),
    .rdata  (rdata)
  );

  assign cs_n = !busy;
  assign rd_n = !(strobe_on && !we_q);
  assign wr_n = !(strobe_on && we_q);
  assign ack  = ack_q;
  assign beat = beat_q;

  always_comb begin
    if (!busy) begin
      ad_oe = '0;
      ad_o  = '0;
    end else if (addr_phase) begin
      ad_oe = '1;
      ad_o  = addr_q;
    end else if (we_q) begin
      ad_oe = '1;
      ad_o  = {{HI_W{1'b0}}, cur_wd};
    end else begin
      ad_oe = {{HI_W{1'b1}}, {HW_W{1'b0}}};
      ad_o  = '0;
    end
  end
endmodule

// File: rtl/slot_seq_chk.sv
module slot_seq_chk #(
  parameter int AD_W = 24,
  parameter int HW_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            cs_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ack,
  input logic            beat,
  input logic            bus_clk,
  input logic            cap_evt,
  input logic [AD_W-1:0] ad_o,
  input logic [AD_W-1:0] ad_oe
);
  localparam int HI_W = AD_W - HW_W;

  // R11
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R11
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (rd_n && wr_n));

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R7
  ack_at_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> (cs_n && !$past(cs_n)));

  // R9
  rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (ad_oe == {{HI_W{1'b1}}, {HW_W{1'b0}}} && ad_o[AD_W-1:HW_W] == '0));

  // R6
  beat_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    beat |-> (rd_n && wr_n && !($past(rd_n) && $past(wr_n))));

  // R3
  cap_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |-> (!rd_n || !wr_n));

  // R10
  bus_clk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (bus_clk != $past(bus_clk)));
endmodule

bind slot_seq slot_seq_chk #(.AD_W(HW_W + HI_W), .HW_W(HW_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs_n   (cs_n),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .ack    (ack),
  .beat   (beat),
  .bus_clk(bus_clk),
  .cap_evt(hw_end),
  .ad_o   (ad_o),
  .ad_oe  (ad_oe)
);

// File: tb/sim_slot_seq.sv
`timescale 1ns/1ps
module sim_slot_seq;
  logic        clk = 1'b0, rst = 1'b1;
  logic        req = 1'b0, req_we = 1'b0;
  logic [1:0]  req_type = 2'd0;
  logic [7:0]  req_len = 8'd0;
  logic [15:0] req_cfg = 16'hE868;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        ack, beat, bus_clk, cs_n, rd_n, wr_n;
  logic [31:0] rdata;
  logic [23:0] ad_o, ad_oe;
  logic [15:0] ad_i;

  always #5 clk = ~clk;

  slot_seq u0 (.*);

  typedef struct { int cyc; logic [31:0] rd; logic we; } exp_t;
  exp_t        aq[$];
  int          sq[$];
  logic [15:0] wq[$];
  int checks = 0, errors = 0;
  int rcnt = 0, rd_idx = 0;
  logic [23:0] exp_addr;
  bit bw_on = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rf(input int k);
    return 16'hA5C3 ^ 16'(k * 293);
  endfunction

  function automatic int f_len(input logic [15:0] c);
    if (c[15:8] != 8'hE8) return 6;
    case (c[7:0])
      8'h60, 8'h70: return 10;
      8'h64:        return 8;
      8'h6C:        return 18;
      default:      return 6;
    endcase
  endfunction

  function automatic int s_len(input logic [15:0] c);
    return (c == 16'hE870 || c == 16'hE878) ? 4 : 6;
  endfunction

  // driver: pushes the expected items, then starts the access
  task automatic issue(input bit we, input logic [1:0] t, input int n,
                       input logic [15:0] c, input logic [23:0] a, input logic [31:0] wd);
    int hw, sum, L;
    exp_t e;
    hw  = (t == 2'd1) ? 2 : (t == 2'd2) ? ((n == 0) ? 1 : n) : 1;
    sum = 0;
    for (int k = 0; k < hw; k++) begin
      L = (k == 0) ? ((we && t == 2'd0) ? f_len(c) - 1 : f_len(c)) : s_len(c);
      sum += L;
      sq.push_back(2 * (L - 1));
      if (we)
        wq.push_back(k == 0 ? wd[15:0] : (t == 2'd1 ? wd[31:16] : wd[15:0] + 16'(k * 16'h0101)));
    end
    e.cyc = 2 * sum + 2;
    e.we  = we;
    e.rd  = (t == 2'd1) ? {rf(rcnt + 1), rf(rcnt)} : {16'h0, rf(rcnt + hw - 1)};
    if (!we) rcnt += hw;
    aq.push_back(e);
    exp_addr = a;
    req_we = we; req_type = t; req_len = 8'(n); req_cfg = c;
    req_addr = a; req_wdata = wd;
    bw_on = we && (t == 2'd2);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (!ack) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops and compares as the design produces results
  int cs_cnt = 0, run = 0;
  bit prev_wr = 0, prev_bclk = 0, started = 0;
  initial ad_i = rf(0);
  always @(negedge clk) begin
    if (rst) begin
      chk(cs_n && rd_n && wr_n && ad_oe == 0 && !ack && !beat, "R1 reset idle",
          {cs_n, rd_n, wr_n, ack, beat, ad_oe[15:0]}, 32'h001C_0000);
    end else begin
      if (started) chk(bus_clk != prev_bclk, "R10 bus_clk toggle", bus_clk, !prev_bclk);
      started = 1; prev_bclk = bus_clk;
      chk(!(!rd_n && !wr_n) && (!cs_n || (rd_n && wr_n)), "R11 strobe exclusivity",
          {cs_n, rd_n, wr_n}, 32'h0);
      if (!cs_n) begin
        cs_cnt++;
        if (cs_cnt == 1) begin
          chk(aq.size() != 0, "R12 unexpected access start", aq.size(), 1);
          chk(ad_oe == 24'hFFFFFF && ad_o == exp_addr && rd_n && wr_n, "R8 address cycle",
              ad_o, exp_addr);
        end
        if (cs_cnt == 3 && aq.size() != 0 && !aq[0].we)
          chk(ad_oe == 24'hFF0000 && ad_o[23:16] == 0, "R9 read line drive", ad_oe, 24'hFF0000);
      end
      if (!rd_n || !wr_n) begin
        run++;
        prev_wr = !wr_n;
      end else if (run > 0) begin
        if (sq.size() == 0) chk(0, "R3 unexpected strobe", run, 0);
        else begin
          int e;
          e = sq.pop_front();
          chk(run == e, "R3/R4 strobe low clocks", run, e);
        end
        chk(beat, "R6 beat after strobe rise", beat, 1);
        if (prev_wr) begin
          logic [15:0] w;
          w = (wq.size() != 0) ? wq.pop_front() : 16'hxxxx;
          chk(ad_o[15:0] === w, "R5/R6 write halfword", ad_o[15:0], w);
        end else begin
          rd_idx++;
          ad_i = rf(rd_idx);
        end
        run = 0;
      end
      if (ack) begin
        if (aq.size() == 0) chk(0, "R12 unexpected ack", ack, 0);
        else begin
          exp_t e;
          e = aq.pop_front();
          chk(cs_cnt == e.cyc, "R7 cs_n low clocks", cs_cnt, e.cyc);
          if (!e.we) chk(rdata == e.rd, "R9/R5 read data at ack", rdata, e.rd);
        end
        cs_cnt = 0;
      end
      if (beat && bw_on) req_wdata[15:0] = req_wdata[15:0] + 16'h0101;
    end
  end

  initial begin
    bit ph0, ph1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    issue(0, 2'd0, 0, 16'hE868, 24'h123456, 32'h0);          // R2 single read 6
    issue(1, 2'd0, 0, 16'hE860, 24'h00ABCD, 32'h0000_BEEF);  // R4 single write 10-1
    issue(1, 2'd1, 0, 16'hE864, 24'h0F0F0F, 32'hCAFE_1234);  // R5 double write 8/6
    issue(0, 2'd1, 0, 16'hE870, 24'h222222, 32'h0);          // R5 double read 10/4
    issue(0, 2'd2, 3, 16'hE86C, 24'h333333, 32'h0);          // R6 burst read 18/6
    issue(1, 2'd2, 4, 16'hE878, 24'h444444, 32'h0000_1000);  // R6 burst write 6/4
    issue(0, 2'd0, 0, 16'h1234, 24'h555555, 32'h0);          // R2 unlisted -> 6/6
    issue(0, 2'd2, 0, 16'hE870, 24'h666666, 32'h0);          // R6 length 0 as 1
    issue(1, 2'd0, 0, 16'hE878, 24'h777777, 32'h0000_0F0F);  // R4 single write 6-1
    // R10 start in both bus clock phases
    while (bus_clk != 1'b0) @(negedge clk);
    ph0 = bus_clk;
    issue(0, 2'd0, 0, 16'hE878, 24'h888888, 32'h0);
    while (bus_clk != 1'b1) @(negedge clk);
    ph1 = bus_clk;
    issue(0, 2'd0, 0, 16'hE878, 24'h888888, 32'h0);
    chk(ph0 != ph1, "R10 both start phases covered", ph1, !ph0);
    // R12 request while busy is ignored
    begin
      exp_t e;
      e.cyc = 2 * (18 + 6) + 2; e.we = 0; e.rd = {16'h0, rf(rcnt + 1)};
      rcnt += 2;
      sq.push_back(34); sq.push_back(10);
      aq.push_back(e);
      exp_addr = 24'h999999;
      req_we = 0; req_type = 2'd2; req_len = 8'd2; req_cfg = 16'hE86C;
      req_addr = 24'h999999; bw_on = 0;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (4) @(negedge clk);
      req_we = 1; req_type = 2'd2; req_len = 8'd5; req_cfg = 16'hE860; req = 1'b1;
      repeat (4) @(negedge clk);
      req = 1'b0;
      while (!ack) @(negedge clk);
      begin
        bit quiet;
        quiet = 1;
        repeat (12) begin
          @(negedge clk);
          if (!cs_n) quiet = 0;
        end
        chk(quiet, "R12 no access after busy request", quiet, 1);
      end
    end
    chk(aq.size() == 0 && sq.size() == 0 && wq.size() == 0, "R7 scoreboard drained",
        aq.size() + sq.size() + wq.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=%0d exp=0", 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule